// File: doc/BRIEF.md
# Linked Command-Packet Chain Walker

This block follows a chain of command packets stored in word-addressed memory and streams each packet's payload words to a graphics command port. Each packet starts with a header word. The header holds a payload length and a pointer to the next packet. Payload words sit at consecutive word addresses directly after their header.

A walk begins when a start request arrives with a pointer. The walker then runs on its own. It reads a header, streams the payload through a one-word holding register under valid/ready flow control, and then follows the pointer. It stops for one of three reasons:

- a terminating pointer,
- a revisited address that shows an endless loop,
- a packet limit for runaway chains.

At the end the walker reports the pointer it stopped on and the total number of memory words that the chain accounts for.

Top module: `chain_walker`

## Requirements
- R1: A header word carries the payload word count in bits 31:24 and the next-packet pointer in bits 23:0. The walker reads the header, then reads exactly that many payload words from the word addresses that follow it. It delivers them on the output stream in address order. Memory data returns on the read-data input one cycle after a read request.
- R2: The start pointer and every followed pointer are masked to a word-aligned 21-bit byte address (AND with 0x1FFFFC) before use. The memory read address is byte-address bits 20:2.
- R3: The walk ends normally when a next pointer has bit 23 set, whatever its other bits. The final-pointer output then holds that raw 24-bit pointer. The start packet is always visited, because masking clears bit 23.
- R4: A payload count of zero is legal. The walker reads only the header and moves straight on to the pointer.
- R5: The word-count output equals 1 (for the initial pointer) plus, for every header read, the payload count plus 1.
- R6: The loop guard keeps three addresses, all set to 0xFFFFFF when a walk starts:
  - the last visited address;
  - the latest address that was lower than the one before it;
  - the latest address that was equal to or higher than the one before it.

  A visit whose address equals either of the last two ends the walk before its header is read. The final-pointer output then holds that masked address.
- R7: After MAX_PACKETS headers have been read (parameter, default 2,000,000), the next visit ends the walk without reading. The final-pointer output then holds that masked address. A chain that terminates after exactly MAX_PACKETS headers ends normally.
- R8: While output valid is high and ready is low, the output data holds steady and valid stays high. No payload read is issued unless the holding register will be free to take the word. No word is lost or repeated.
- R9: After the last payload word has been accepted, done is high for exactly one cycle. Busy goes high the cycle after a start is accepted and is low the cycle after done.
- R10: A start request that arrives while busy is ignored, and the running walk finishes with its own results.
- R11: After reset, busy, done, output valid and memory read are low, and the word count and final pointer are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Start request, taken when idle |
| startAddr | input | 24 | Pointer to the first packet |
| memRen | output | 1 | Memory read strobe |
| memAddr | output | ADDR_W-2 | Memory word address |
| memRdata | input | 32 | Read data, valid one cycle after memRen |
| outValid | output | 1 | Payload word available |
| outReady | input | 1 | Consumer accepts the word |
| outData | output | 32 | Payload word |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion pulse |
| finalPtr | output | 24 | Pointer on which the walk stopped |
| wordCount | output | WC_W | Total words the chain accounts for |

## Verification
The loop-guard registers and the packet counter are invisible until a walk ends, so a corrupted tracker or counter shows up only at the done pulse. It then appears as a wrong final pointer together with a word count that is too small or too large. A tracker that is not cleared between walks makes a repeated walk stop immediately, with a word count of 1. The bench therefore runs the same loop and limit chains back to back.

A fault in the holding register or payload address shows up within one or two cycles as a changed word under stall, or a payload tag out of sequence.

// File: rtl/chain_walker_pkg.sv
package chain_walker_pkg;

  localparam int HDR_W     = 32;
  localparam int PTR_W     = 24;
  localparam int CNT_LSB   = 24;
  localparam int TERM_BIT  = 23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_VISIT,
    ST_HDR,
    ST_PAYRD,
    ST_PAYCAP,
    ST_FINISH
  } walk_state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadStart;
    logic visit;
    logic latchHdr;
    logic payRead;
    logic payCapture;
    logic follow;
    logic finalCur;
    logic finalNext;
  } walk_strobe_t;

  // conditions from datapath to control
  typedef struct packed {
    logic loopHit;
    logic limitHit;
    logic remZero;
    logic linkTerm;
    logic holdRoom;
    logic holdValid;
  } walk_status_t;

endpackage

// File: rtl/chain_walker_loopguard.sv
module chain_walker_loopguard
  import chain_walker_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             update,
  input  logic [PTR_W-1:0] addr,
  output logic             hit
);

  localparam logic [PTR_W-1:0] SEED = '1;

  logic [PTR_W-1:0] lastAddr, backAddr, fwdAddr;

  assign hit = (addr == backAddr) || (addr == fwdAddr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lastAddr <= SEED;
      backAddr <= SEED;
      fwdAddr  <= SEED;
    end else if (clear) begin
      lastAddr <= SEED;
      backAddr <= SEED;
      fwdAddr  <= SEED;
    end else if (update) begin
      if (addr < lastAddr) backAddr <= addr;
      else                 fwdAddr  <= addr;
      lastAddr <= addr;
    end
  end

  AST_NO_VISIT_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    update |-> !hit); // R6

endmodule

// File: rtl/chain_walker_dp.sv
module chain_walker_dp
  import chain_walker_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int WC_W        = 32,
  parameter int MAX_PACKETS = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  walk_strobe_t      strb,
  input  logic [PTR_W-1:0]  startAddr,
  input  logic [HDR_W-1:0]  memRdata,
  input  logic              outReady,
  output logic              memRen,
  output logic [ADDR_W-3:0] memAddr,
  output logic              outValid,
  output logic [HDR_W-1:0]  outData,
  output logic [PTR_W-1:0]  finalPtr,
  output logic [WC_W-1:0]   wordCount,
  output walk_status_t      status
);

  localparam int WIDX_W = ADDR_W - 2;
  localparam int PKT_W  = $clog2(MAX_PACKETS + 1);
  localparam int CNT_W  = HDR_W - CNT_LSB;
  localparam logic [PTR_W-1:0] ADDR_MASK = PTR_W'(((64'd1 << ADDR_W) - 64'd1) & ~64'd3);

  logic [PTR_W-1:0]  curAddr;
  logic [PTR_W-1:0]  nextPtr;
  logic [WIDX_W-1:0] payIdx;
  logic [CNT_W-1:0]  remCnt;
  logic [PKT_W-1:0]  pktCount;
  logic              holdValid;
  logic [HDR_W-1:0]  holdData;
  logic              guardHit;

  chain_walker_loopguard u_guard (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (strb.loadStart),
    .update (strb.visit),
    .addr   (curAddr),
    .hit    (guardHit)
  );

  assign memRen  = strb.visit | strb.payRead;
  assign memAddr = strb.visit ? curAddr[ADDR_W-1:2] : payIdx;

  assign outValid = holdValid;
  assign outData  = holdData;

  assign status.loopHit   = guardHit;
  assign status.limitHit  = (pktCount == PKT_W'(MAX_PACKETS));
  assign status.remZero   = (remCnt == '0);
  assign status.linkTerm  = nextPtr[TERM_BIT];
  assign status.holdRoom  = !holdValid || outReady;
  assign status.holdValid = holdValid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr   <= '0;
      nextPtr   <= '0;
      payIdx    <= '0;
      remCnt    <= '0;
      pktCount  <= '0;
      finalPtr  <= '0;
      wordCount <= '0;
    end else begin
      if (strb.loadStart) begin
        curAddr   <= startAddr & ADDR_MASK;
        wordCount <= WC_W'(1);
        pktCount  <= '0;
      end
      if (strb.visit) begin
        pktCount <= pktCount + PKT_W'(1);
        payIdx   <= curAddr[ADDR_W-1:2] + WIDX_W'(1);
      end
      if (strb.latchHdr) begin
        remCnt    <= memRdata[HDR_W-1:CNT_LSB];
        nextPtr   <= memRdata[PTR_W-1:0];
        wordCount <= wordCount + WC_W'(memRdata[HDR_W-1:CNT_LSB]) + WC_W'(1);
      end
      if (strb.payRead) begin
        payIdx <= payIdx + WIDX_W'(1);
        remCnt <= remCnt - CNT_W'(1);
      end
      if (strb.follow)    curAddr  <= nextPtr & ADDR_MASK;
      if (strb.finalCur)  finalPtr <= curAddr;
      if (strb.finalNext) finalPtr <= nextPtr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      holdValid <= 1'b0;
      holdData  <= '0;
    end else if (strb.payCapture) begin
      holdValid <= 1'b1;
      holdData  <= memRdata;
    end else if (holdValid && outReady) begin
      holdValid <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (outValid && !outReady) |=> (outValid && $stable(outData))); // R8

  AST_NO_CLOBBER: assert property (@(posedge clk) disable iff (!rst_n)
    strb.payCapture |-> !holdValid); // R8

  AST_PKT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    strb.visit |-> (pktCount < PKT_W'(MAX_PACKETS))); // R7

endmodule

// File: rtl/chain_walker_ctrl.sv
module chain_walker_ctrl
  import chain_walker_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         startValid,
  input  walk_status_t status,
  output walk_strobe_t strb,
  output logic         busy,
  output logic         done
);

  walk_state_e state, nextState;

  always_comb begin
    strb      = '0;
    nextState = state;
    done      = 1'b0;
    unique case (state)
      ST_IDLE: begin
        if (startValid) begin
          strb.loadStart = 1'b1;
          nextState      = ST_VISIT;
        end
      end
      ST_VISIT: begin
        if (status.limitHit || status.loopHit) begin
          strb.finalCur = 1'b1;
          nextState     = ST_FINISH;
        end else begin
          strb.visit = 1'b1;
          nextState  = ST_HDR;
        end
      end
      ST_HDR: begin
        strb.latchHdr = 1'b1;
        nextState     = ST_PAYRD;
      end
      ST_PAYRD: begin
        if (status.remZero) begin
          if (status.linkTerm) begin
            strb.finalNext = 1'b1;
            nextState      = ST_FINISH;
          end else begin
            strb.follow = 1'b1;
            nextState   = ST_VISIT;
          end
        end else if (status.holdRoom) begin
          strb.payRead = 1'b1;
          nextState    = ST_PAYCAP;
        end
      end
      ST_PAYCAP: begin
        strb.payCapture = 1'b1;
        nextState       = ST_PAYRD;
      end
      ST_FINISH: begin
        if (!status.holdValid) begin
          done      = 1'b1;
          nextState = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign busy = (state != ST_IDLE);

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startValid) |=> busy); // R9

  AST_LOOP_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_VISIT && status.loopHit) |=> (state == ST_FINISH)); // R6

endmodule

// File: rtl/chain_walker.sv
module chain_walker
  import chain_walker_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int WC_W        = 32,
  parameter int MAX_PACKETS = 2000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              startValid,
  input  logic [23:0]       startAddr,
  output logic              memRen,
  output logic [ADDR_W-3:0] memAddr,
  input  logic [31:0]       memRdata,
  output logic              outValid,
  input  logic              outReady,
  output logic [31:0]       outData,
  output logic              busy,
  output logic              done,
  output logic [23:0]       finalPtr,
  output logic [WC_W-1:0]   wordCount
);

  walk_strobe_t strb;
  walk_status_t status;

  chain_walker_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .startValid (startValid),
    .status     (status),
    .strb       (strb),
    .busy       (busy),
    .done       (done)
  );

  chain_walker_dp #(
    .ADDR_W      (ADDR_W),
    .WC_W        (WC_W),
    .MAX_PACKETS (MAX_PACKETS)
  ) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .strb      (strb),
    .startAddr (startAddr),
    .memRdata  (memRdata),
    .outReady  (outReady),
    .memRen    (memRen),
    .memAddr   (memAddr),
    .outValid  (outValid),
    .outData   (outData),
    .finalPtr  (finalPtr),
    .wordCount (wordCount),
    .status    (status)
  );

  AST_ONE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    memRen |=> !memRen); // R1

endmodule

// File: tb/tb_chain_walker.sv
`timescale 1ns/1ps
module tb_chain_walker;

  localparam int ADDR_W = 21;
  localparam int LIMIT  = 6;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              startValid = 1'b0;
  logic [23:0]       startAddr = '0;
  logic              memRen;
  logic [ADDR_W-3:0] memAddr;
  logic [31:0]       memRdata = '0;
  logic              outValid;
  logic              outReady = 1'b0;
  logic [31:0]       outData;
  logic              busy;
  logic              done;
  logic [23:0]       finalPtr;
  logic [31:0]       wordCount;

  always #2.5 clk = ~clk;

  chain_walker #(.ADDR_W(ADDR_W), .WC_W(32), .MAX_PACKETS(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .startValid(startValid), .startAddr(startAddr),
    .memRen(memRen), .memAddr(memAddr), .memRdata(memRdata),
    .outValid(outValid), .outReady(outReady), .outData(outData),
    .busy(busy), .done(done), .finalPtr(finalPtr), .wordCount(wordCount)
  );

  logic [31:0] mem [1024];
  always @(posedge clk) if (memRen) memRdata <= mem[memAddr[9:0]];

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      checks = checks + 1;
      fails  = fails + 1;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  function automatic logic [31:0] hdr(input logic [7:0] cnt, input logic [23:0] nxt);
    return {cnt, nxt};
  endfunction

  function automatic void put(input logic [23:0] byteAddr, input logic [31:0] val);
    mem[byteAddr[11:2]] = val;
  endfunction

  typedef struct packed {
    logic [23:0] start;
    logic [23:0] fin;
    logic [31:0] words;
    logic [7:0]  len;
    logic [31:0] tag;
    logic [1:0]  rdy;
    logic        poke;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{24'h000100, 24'hFFFFFF, 32'd6, 8'd3, 32'h1001, 2'd0, 1'b0},
    '{24'hE00302, 24'h800000, 32'd5, 8'd2, 32'h2001, 2'd1, 1'b0},
    '{24'h000400, 24'h000400, 32'd5, 8'd2, 32'h3001, 2'd1, 1'b0},
    '{24'h000600, 24'h000600, 32'd2, 8'd0, 32'h0000, 2'd0, 1'b0},
    '{24'h000600, 24'h000600, 32'd2, 8'd0, 32'h0000, 2'd0, 1'b0},
    '{24'h000700, 24'h000760, 32'd7, 8'd0, 32'h0000, 2'd0, 1'b0},
    '{24'h000710, 24'hFFFFFF, 32'd7, 8'd0, 32'h0000, 2'd0, 1'b0},
    '{24'hE00302, 24'h800000, 32'd5, 8'd2, 32'h2001, 2'd2, 1'b1}
  };

  task automatic runVec(input vec_t v, input int idx);
    int cyc = 0;
    int got = 0;
    int dataErr = 0;
    int stallErr = 0;
    int doneCnt = 0;
    logic prevStall = 1'b0;
    logic [31:0] prevData = '0;
    logic [23:0] fin = '0;
    logic [31:0] wc = '0;
    @(negedge clk);
    startValid = 1'b1;
    startAddr  = v.start;
    outReady   = 1'b0;
    @(negedge clk);
    startValid = 1'b0;
    #1;
    chk(busy, $sformatf("vec %0d busy after start R9", idx), {31'd0, busy}, 32'd1);
    while (doneCnt == 0 && cyc < 3000) begin
      case (v.rdy)
        2'd0:    outReady = 1'b1;
        2'd1:    outReady = (cyc % 3) != 0;
        default: outReady = (cyc >= 12);
      endcase
      startValid = v.poke && (cyc == 3);
      if (v.poke) startAddr = 24'h000100;
      #0.5;
      if (prevStall && (!outValid || outData != prevData)) stallErr++;
      if (outValid && outReady) begin
        if (outData != v.tag + got) dataErr++;
        got++;
      end
      prevStall = outValid && !outReady;
      prevData  = outData;
      if (done) begin
        doneCnt++;
        fin = finalPtr;
        wc  = wordCount;
      end
      @(negedge clk);
      #1;
      cyc++;
    end
    startValid = 1'b0;
    chk(doneCnt == 1, $sformatf("vec %0d done seen R9", idx), doneCnt, 32'd1);
    chk(!done && !busy, $sformatf("vec %0d done one cycle, idle after R9", idx),
        {30'd0, done, busy}, 32'd0);
    chk(fin == v.fin, $sformatf("vec %0d final pointer R3 R6 R7 R10", idx), {8'd0, fin}, {8'd0, v.fin});
    chk(wc == v.words, $sformatf("vec %0d word count R5 R6 R7", idx), wc, v.words);
    chk(got == int'(v.len), $sformatf("vec %0d payload words R1 R4", idx), got, {24'd0, v.len});
    chk(dataErr == 0, $sformatf("vec %0d payload order R1 R2", idx), dataErr, 32'd0);
    chk(stallErr == 0, $sformatf("vec %0d stall hold R8", idx), stallErr, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'hDEAD0000 | i;
    // basic two-packet chain ending on 0xFFFFFF
    put(24'h100, hdr(8'd2, 24'h000200));
    put(24'h104, 32'h1001);
    put(24'h108, 32'h1002);
    put(24'h200, hdr(8'd1, 24'hFFFFFF));
    put(24'h204, 32'h1003);
    // zero-count packet, masked next pointer, other terminator value
    put(24'h300, hdr(8'd0, 24'h600281));
    put(24'h280, hdr(8'd2, 24'h800000));
    put(24'h284, 32'h2001);
    put(24'h288, 32'h2002);
    // two-packet loop
    put(24'h400, hdr(8'd1, 24'h000500));
    put(24'h404, 32'h3001);
    put(24'h500, hdr(8'd1, 24'h000400));
    put(24'h504, 32'h3002);
    // self loop
    put(24'h600, hdr(8'd0, 24'h000600));
    // long ascending chain for the packet limit
    for (int k = 0; k < 6; k++)
      put(24'h700 + 24'(k * 16), hdr(8'd0, 24'h710 + 24'(k * 16)));
    put(24'h760, hdr(8'd0, 24'hFFFFFF));

    #1;
    // R11 reset state
    chk(!busy && !done && !outValid && !memRen, "reset controls R11",
        {28'd0, busy, done, outValid, memRen}, 32'd0);
    chk(wordCount == 0 && finalPtr == 0, "reset counters R11", wordCount | {8'd0, finalPtr}, 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!busy && !memRen, "idle after reset R11", {30'd0, busy, memRen}, 32'd0);

    for (int i = 0; i < NV; i++) runVec(VECS[i], i);

    // R10 ignored start must not leave a second walk running
    repeat (4) @(negedge clk);
    #1;
    chk(!busy && !memRen, "no walk after ignored start R10", {30'd0, busy, memRen}, 32'd0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule